// File: doc/BRIEF.md
# Transmitter Power-Up Step Sequencer

This block brings the analog front end of a serial display transmitter out of power-down in a fixed order. The built-in sequencer is not used, so this block drives seven active-high power-down lines directly: output port, PLL, bandgap, VCO, PLL capacitor, I/O deep-power-down and pad calibration. It moves through five steps. Between steps it waits a set number of microsecond ticks. The first release depends on a request/status handshake with an external I/O deep-power-down controller.

A single-cycle start pulse launches the sequence. If the link is already up, either because an earlier run of this block finished or because the caller reports that lane 0 is already enabled, the block pulses done and touches nothing. A deep-power-down exit that never completes ends the run. The lines are then left fully powered down and an error flag is raised.

Top module: `tx_pwrup_seq`

## Requirements
- R1: Out of reset all seven power-down lines are high (bit order in the bench vector, LSB first: port, pll, bandgap, vco, pll-cap, io, cal; reset value 7'h7F). done, err, the deep-power-down request and the sample enable are low.
- R2: An accepted start puts all seven lines high (step 1). The deep-power-down request and the sample enable rise in the next cycle, and the timing select then reads 10.
- R3: The deep-power-down status is checked once every 20 ticks while the request is high. At the first check that finds it clear, the request and the sample enable drop and the I/O line is released. The I/O line never drops while the request is high.
- R4: If the status is still set after 500 checks (10000 ticks), the run aborts. err goes high, the request and the sample enable drop, all seven lines stay high and no done is issued. err stays high until the next start and clears in the cycle after that start.
- R5: Exactly 15 ticks after the I/O line is released, the bandgap line is released.
- R6: Exactly 25 ticks after the bandgap release, the PLL, VCO and PLL-capacitor lines are released in the same cycle.
- R7: Exactly 225 ticks after that, the port line is released and done pulses for one cycle. A sticky powered-up state is recorded.
- R8: The pad-calibration line stays high at all times.
- R9: A start while powered up, or while lane0_on_i is high, pulses done in the next cycle. It changes no power-down line and raises no request.
- R10: During a run, a line that has been released is never re-asserted.
- R11: A start that arrives while a run is in progress is ignored. The run keeps its timing and issues a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle power-up request |
| lane0_on_i | input | 1 | Lane 0 already enabled; skip the sequence |
| dpd_busy_i | input | 1 | Deep-power-down status still set (1 = not yet exited) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| pd_port_o | output | 1 | Port power-down |
| pd_pll_o | output | 1 | PLL power-down |
| pd_bg_o | output | 1 | Bandgap power-down |
| pd_vco_o | output | 1 | VCO power-down |
| pd_cap_o | output | 1 | PLL capacitor power-down |
| pd_io_o | output | 1 | I/O deep-power-down |
| pd_cal_o | output | 1 | Pad calibration power-down |
| dpd_req_o | output | 1 | Deep-power-down exit request |
| dpd_sample_o | output | 1 | Deep-power-down sample enable |
| dpd_timsel_o | output | 8 | Deep-power-down timing select (10 while sampling) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Deep-power-down exit timeout |

## Verification
The embedded assertions check the orderings on every cycle:
- calibration is always held;
- the I/O line is never released while the request is outstanding;
- the bandgap is only released after the I/O line;
- the PLL group moves as one;
- the port is released last;
- the timing select value is present whenever sampling is enabled;
- a skipped start produces an immediate done with unchanged lines.

The exact tick counts between releases, the poll spacing, the 10000-tick abort, the persistence of err, and the way a second start is ignored mid-run can only be shown by the bench's directed scenarios. The bench does this by counting ticks in each window at the ports.

// File: rtl/pwrseq_pkg.sv
// Package: shared types and the release-step table of the power-up sequencer.
// Assumes control bit order port, pll, bandgap, vco, cap, io, cal (LSB first).
package pwrseq_pkg;

    localparam int NUM_CTL = 7;
    localparam int STEP_W  = 3;

    localparam int CTL_PORT = 0;
    localparam int CTL_PLL  = 1;
    localparam int CTL_BG   = 2;
    localparam int CTL_VCO  = 3;
    localparam int CTL_CAP  = 4;
    localparam int CTL_IO   = 5;
    localparam int CTL_CAL  = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DPD  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

    // Step at which a control is first released; 7 means never.
    function automatic int release_step(input int idx);
        case (idx)
            CTL_IO:   return 2;
            CTL_BG:   return 3;
            CTL_PLL,
            CTL_VCO,
            CTL_CAP:  return 4;
            CTL_PORT: return 5;
            default:  return 7;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_tick_timer.sv
// Module: down-counter in microsecond ticks.
// Loads a value, counts one down on each tick, and holds at zero.
// Assumes tick is a one-cycle pulse; a load wins over a tick in the same cycle.
module pwrseq_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Counter update: load, else decrement on tick while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // Once empty, the counter stays empty until reloaded (no wrap).
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/pwrseq_dpd_ctrl.sv
// Module: request/status handshake with the I/O deep-power-down controller.
// On go it raises request and sample enable (timing select applied).
// It checks the status every POLL_US ticks, reports ok at the first clear check,
// and reports fail after NUM_POLLS checks that are still busy.
// Assumes go only arrives while inactive.
module pwrseq_dpd_ctrl #(
    parameter int CNT_W     = 8,
    parameter int POLL_US   = 20,
    parameter int NUM_POLLS = 500,
    parameter int TIMSEL    = 10,
    parameter int TIMSEL_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic                busy_i,
    input  logic                tick_i,
    output logic                req_o,
    output logic                sample_o,
    output logic [TIMSEL_W-1:0] timsel_o,
    output logic                ok_o,
    output logic                fail_o
);
    localparam int POLL_CNT_W = $clog2(NUM_POLLS + 1);

    logic                  active_q;
    logic [POLL_CNT_W-1:0] polls_q;
    logic                  tmr_zero;
    logic                  check;
    logic                  tmr_load;

    assign check    = active_q && tmr_zero;
    assign ok_o     = check && !busy_i;
    assign fail_o   = check && busy_i && (polls_q == POLL_CNT_W'(NUM_POLLS - 1));
    assign tmr_load = go_i || (check && busy_i && !fail_o);

    pwrseq_tick_timer #(.CNT_W(CNT_W)) u_poll_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (CNT_W'(POLL_US)),
        .tick_i     (tick_i),
        .zero_o     (tmr_zero)
    );

    // Handshake activity and poll count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            polls_q  <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            polls_q  <= '0;
        end else if (ok_o || fail_o) begin
            active_q <= 1'b0;
        end else if (check) begin
            polls_q  <= polls_q + 1'b1;
        end
    end

    assign req_o    = active_q;
    assign sample_o = active_q;
    assign timsel_o = active_q ? TIMSEL_W'(TIMSEL) : '0;

    // Sampling always carries the configured timing select.
    p_timsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (timsel_o == TIMSEL_W'(TIMSEL)));
    // A finished handshake drops the request on the next cycle.
    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || fail_o) |=> !req_o);

endmodule

// File: rtl/pwrseq_ctl_decode.sv
// Module: maps the current step to the seven power-down levels.
// A control is high while the step is below its release step.
// Assumes step is in the range 1..5.
module pwrseq_ctl_decode
    import pwrseq_pkg::*;
(
    input  logic [STEP_W-1:0]  step_i,
    output logic [NUM_CTL-1:0] ctl_o
);
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        // Per-line compare against its release step.
        assign ctl_o[g] = (int'(step_i) < release_step(g));
    end
endmodule

// File: rtl/tx_pwrup_seq.sv
// Module: five-step transmitter power-up sequencer (top).
// Step 1 asserts all lines. Step 2 exits deep power-down through the handshake.
// Steps 2 to 4 each wait a tick count before the next release, and step 5
// releases the port. It skips when already powered or lane 0 is on.
// Assumes us_tick_i is a one-cycle pulse, at most every other cycle.
module tx_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int WAIT_IO_US     = 15,
    parameter int WAIT_BG_US     = 25,
    parameter int WAIT_PLL_US    = 225,
    parameter int POLL_US        = 20,
    parameter int DPD_TIMEOUT_US = 10000,
    parameter int TIMSEL         = 10,
    parameter int TIMSEL_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                lane0_on_i,
    input  logic                dpd_busy_i,
    input  logic                us_tick_i,
    output logic                pd_port_o,
    output logic                pd_pll_o,
    output logic                pd_bg_o,
    output logic                pd_vco_o,
    output logic                pd_cap_o,
    output logic                pd_io_o,
    output logic                pd_cal_o,
    output logic                dpd_req_o,
    output logic                dpd_sample_o,
    output logic [TIMSEL_W-1:0] dpd_timsel_o,
    output logic                done_o,
    output logic                err_o
);
    localparam int MAX_A     = (WAIT_IO_US > WAIT_BG_US) ? WAIT_IO_US : WAIT_BG_US;
    localparam int MAX_B     = (WAIT_PLL_US > POLL_US) ? WAIT_PLL_US : POLL_US;
    localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int NUM_POLLS = DPD_TIMEOUT_US / POLL_US;

    seq_state_t         st_q, st_d;
    logic [STEP_W-1:0]  step_q, step_d;
    logic               powered_q, powered_d;
    logic               err_q, err_d;
    logic               done_q, done_d;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic               dpd_go, dpd_ok, dpd_fail;
    logic               skip;
    logic [NUM_CTL-1:0] ctl;

    assign skip = powered_q || lane0_on_i;

    pwrseq_tick_timer #(.CNT_W(CNT_W)) u_step_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (us_tick_i),
        .zero_o     (tmr_zero)
    );

    pwrseq_dpd_ctrl #(
        .CNT_W     (CNT_W),
        .POLL_US   (POLL_US),
        .NUM_POLLS (NUM_POLLS),
        .TIMSEL    (TIMSEL),
        .TIMSEL_W  (TIMSEL_W)
    ) u_dpd (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (dpd_go),
        .busy_i   (dpd_busy_i),
        .tick_i   (us_tick_i),
        .req_o    (dpd_req_o),
        .sample_o (dpd_sample_o),
        .timsel_o (dpd_timsel_o),
        .ok_o     (dpd_ok),
        .fail_o   (dpd_fail)
    );

    pwrseq_ctl_decode u_dec (
        .step_i (step_q),
        .ctl_o  (ctl)
    );

    // Next-state, step advance, timer loads and handshake launch.
    always_comb begin
        st_d      = st_q;
        step_d    = step_q;
        powered_d = powered_q;
        err_d     = err_q;
        done_d    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        dpd_go    = 1'b0;
        case (st_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    err_d = 1'b0;
                    if (skip) begin
                        done_d = 1'b1;
                    end else begin
                        step_d = STEP_W'(1);
                        dpd_go = 1'b1;
                        st_d   = SEQ_DPD;
                    end
                end
            end
            SEQ_DPD: begin
                if (dpd_ok) begin
                    step_d   = STEP_W'(2);
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WAIT_IO_US);
                    st_d     = SEQ_WAIT;
                end else if (dpd_fail) begin
                    err_d = 1'b1;
                    st_d  = SEQ_IDLE;
                end
            end
            SEQ_WAIT: begin
                if (tmr_zero) begin
                    case (step_q)
                        STEP_W'(2): begin
                            step_d   = STEP_W'(3);
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(WAIT_BG_US);
                        end
                        STEP_W'(3): begin
                            step_d   = STEP_W'(4);
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(WAIT_PLL_US);
                        end
                        default: begin
                            step_d    = STEP_W'(5);
                            powered_d = 1'b1;
                            done_d    = 1'b1;
                            st_d      = SEQ_IDLE;
                        end
                    endcase
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // State registers; reset holds every line powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SEQ_IDLE;
            step_q    <= STEP_W'(1);
            powered_q <= 1'b0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            st_q      <= st_d;
            step_q    <= step_d;
            powered_q <= powered_d;
            err_q     <= err_d;
            done_q    <= done_d;
        end
    end

    assign pd_port_o = ctl[CTL_PORT];
    assign pd_pll_o  = ctl[CTL_PLL];
    assign pd_bg_o   = ctl[CTL_BG];
    assign pd_vco_o  = ctl[CTL_VCO];
    assign pd_cap_o  = ctl[CTL_CAP];
    assign pd_io_o   = ctl[CTL_IO];
    assign pd_cal_o  = ctl[CTL_CAL];
    assign done_o    = done_q;
    assign err_o     = err_q;

    // Calibration is never released.
    p_cal_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_cal_o);
    // I/O stays down while the deep-power-down request is outstanding.
    p_io_waits_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_req_o |-> pd_io_o);
    // Bandgap is released only after the I/O line.
    p_bg_after_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_bg_o |-> !pd_io_o);
    // PLL, VCO and capacitor move together, after the bandgap.
    p_pll_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pll_o == pd_vco_o) && (pd_vco_o == pd_cap_o) && (!pd_pll_o -> !pd_bg_o));
    // Port is released last.
    p_port_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_port_o |-> !pd_pll_o);
    // A run in progress never re-asserts a released line.
    p_monotonic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SEQ_IDLE) |=> ((ctl & ~$past(ctl)) == '0));
    // A skipped start gives done at once and changes no line.
    p_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_IDLE && start_i && skip) |=> (done_o && $stable(ctl) && !dpd_req_o));
    // An aborted run leaves every line asserted.
    p_abort_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (&ctl && !done_o));

endmodule

// File: tb/sim_tx_pwrup_seq.sv
// Bench: directed scenarios for the power-up sequencer, one task each.
module sim_tx_pwrup_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       lane0_on_i = 1'b0;
    logic       dpd_busy_i = 1'b1;
    logic       us_tick_i = 1'b0;
    logic       pd_port_o, pd_pll_o, pd_bg_o, pd_vco_o, pd_cap_o, pd_io_o, pd_cal_o;
    logic       dpd_req_o, dpd_sample_o, done_o, err_o;
    logic [7:0] dpd_timsel_o;

    int n_run = 0;
    int n_fail = 0;
    int c_req, c_w15, c_w25, c_w225, c_done;
    bit cal_drop;
    bit finished = 0;

    always #10 clk = ~clk;

    tx_pwrup_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane0_on_i(lane0_on_i),
        .dpd_busy_i(dpd_busy_i), .us_tick_i(us_tick_i),
        .pd_port_o(pd_port_o), .pd_pll_o(pd_pll_o), .pd_bg_o(pd_bg_o),
        .pd_vco_o(pd_vco_o), .pd_cap_o(pd_cap_o), .pd_io_o(pd_io_o),
        .pd_cal_o(pd_cal_o), .dpd_req_o(dpd_req_o), .dpd_sample_o(dpd_sample_o),
        .dpd_timsel_o(dpd_timsel_o), .done_o(done_o), .err_o(err_o)
    );

    // Tick every other cycle, changed mid-cycle after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            us_tick_i = ~us_tick_i;
        end
    end

    function automatic logic [6:0] ctl();
        return {pd_cal_o, pd_io_o, pd_cap_o, pd_vco_o, pd_bg_o, pd_pll_o, pd_port_o};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        c_req = 0; c_w15 = 0; c_w25 = 0; c_w225 = 0; c_done = 0; cal_drop = 0;
    endtask

    // Advance to the next falling edge and accumulate window tick counts.
    task automatic step();
        @(negedge clk);
        if (us_tick_i) begin
            if (dpd_req_o) c_req++;
            if (!pd_io_o && pd_bg_o) c_w15++;
            if (!pd_bg_o && pd_pll_o) c_w25++;
            if (!pd_pll_o && pd_port_o) c_w225++;
        end
        if (done_o) c_done++;
        if (!pd_cal_o) cal_drop = 1;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ctl() == 7'h7F, "R1 lines", ctl(), 7'h7F);
        chk(!done_o && !err_o, "R1 done/err", {done_o, err_o}, 0);
        chk(!dpd_req_o && !dpd_sample_o, "R1 req/sample", {dpd_req_o, dpd_sample_o}, 0);
    endtask

    // Full run: status clears after 50 ticks, a stray start arrives in step 3.
    task automatic t_full_run();
        bit stray = 0;
        int guard = 0;
        clr();
        dpd_busy_i = 1'b1;
        pulse_start();
        chk(dpd_req_o && dpd_sample_o, "R2 req+sample", {dpd_req_o, dpd_sample_o}, 3);
        chk(dpd_timsel_o == 8'd10, "R2 timsel", dpd_timsel_o, 10);
        chk(ctl() == 7'h7F, "R2 step1 lines", ctl(), 7'h7F);
        while (!done_o && guard < 5000) begin
            if (c_req >= 50) dpd_busy_i = 1'b0;
            if (!stray && !pd_bg_o && pd_pll_o) begin
                start_i = 1'b1;   // R11 stray start
                stray = 1;
            end else begin
                start_i = 1'b0;
            end
            step();
            guard++;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R7 done seen", done_o, 1);
        chk(c_req == 60, "R3 poll ticks", c_req, 60);
        chk(c_w15 == 15, "R5 io->bg ticks", c_w15, 15);
        chk(c_w25 == 25, "R6 bg->pll ticks", c_w25, 25);
        chk(c_w225 == 225, "R7 pll->port ticks", c_w225, 225);
        chk(ctl() == 7'h40, "R7 final lines", ctl(), 7'h40);
        chk(!dpd_req_o && !dpd_sample_o, "R3 req dropped", dpd_req_o, 0);
        step();
        chk(!done_o, "R7 done one cycle", done_o, 0);
        chk(!cal_drop, "R8 cal held", cal_drop, 0);
        chk(c_done == 1 && stray, "R11 single done", c_done, 1);
    endtask

    task automatic t_skip_powered();
        clr();
        pulse_start();
        chk(done_o, "R9 powered done", done_o, 1);
        chk(ctl() == 7'h40, "R9 powered lines", ctl(), 7'h40);
        repeat (10) step();
        chk(c_req == 0 && ctl() == 7'h40, "R9 no request", c_req, 0);
    endtask

    task automatic t_skip_lane0();
        clr();
        lane0_on_i = 1'b1;
        pulse_start();
        chk(done_o, "R9 lane0 done", done_o, 1);
        chk(ctl() == 7'h7F && !dpd_req_o, "R9 lane0 lines", ctl(), 7'h7F);
        lane0_on_i = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_timeout();
        int guard = 0;
        clr();
        dpd_busy_i = 1'b1;
        pulse_start();
        while (!err_o && guard < 30000) begin
            step();
            guard++;
        end
        chk(err_o, "R4 err raised", err_o, 1);
        chk(c_req == 10000, "R4 timeout ticks", c_req, 10000);
        chk(ctl() == 7'h7F, "R4 lines held", ctl(), 7'h7F);
        chk(c_done == 0, "R4 no done", c_done, 0);
        chk(!dpd_req_o && !dpd_sample_o, "R4 req dropped", dpd_req_o, 0);
        repeat (20) step();
        chk(err_o, "R4 err sticky", err_o, 1);
        dpd_busy_i = 1'b0;
        pulse_start();
        chk(!err_o, "R4 err cleared", err_o, 0);
        guard = 0;
        while (!done_o && guard < 5000) begin
            step();
            guard++;
        end
        chk(ctl() == 7'h40, "R7 retry completes", ctl(), 7'h40);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        do_reset();
        t_reset();
        t_full_run();
        t_skip_powered();
        do_reset();
        t_reset();
        t_skip_lane0();
        t_timeout();
        finish_run();
    end
endmodule